// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counting Timer

This block is a memory-mapped timer peripheral. A single prescaler divides the system clock into ticks, and every timer channel uses those ticks. Each channel counts down from a software-written start value. When it passes zero it records an event. It then either reloads and keeps running, or stops. An interrupt is raised for each event on a channel whose interrupt enable is set. The interrupts leave the block either as one line per channel or as one shared line, chosen by a parameter.

Software reaches the block through a plain register bus. The bus has a write strobe, a read strobe, a word address, 32-bit write data and 32-bit read data. Reads are combinational: the read data is valid during the cycle in which the read strobe is high, and it is zero otherwise. A write takes effect at the clock edge that samples the strobe.

Word map: 0 is the prescaler count, 1 is the prescaler start value, and 2 is a read-only configuration word. Channel n occupies words 4+4n (count), 5+4n (start value) and 6+4n (control). The control bits are: bit 0 run, bit 1 auto-repeat, bit 2 load (an action bit), bit 3 interrupt enable and bit 4 event flag. Unmapped words read as zero.

Top module: `tick_timer_bank`

## Requirements
- R1: The prescaler counts down once per clock cycle and restarts from its start value after reaching zero. It produces one tick per (prescaler start + 1) clock cycles, and channels only count on ticks.
- R2: A running channel with auto-repeat set (control bit 1) produces one event every (start + 1) ticks. The interval between interrupt pulses is therefore (prescaler start + 1) * (start + 1) clock cycles.
- R3: When an event occurs on a channel with auto-repeat clear, the channel clears its own run bit (control bit 0), its count stays at 0, and no further events occur.
- R4: Writing 1 to the load bit (control bit 2) copies the channel start value into its count. The load bit always reads back as 0.
- R5: An event on a channel with interrupt enable (bit 3) set sets the event flag (bit 4) and gives a single-cycle interrupt pulse in the cycle the flag rises. With interrupt enable clear, no flag is set and no pulse occurs.
- R6: Writing 1 to bit 4 of a control word clears the event flag. Writing 0 there leaves the flag unchanged. An event in the same cycle as a clearing write keeps the flag set.
- R7: The configuration word (word 2) is read-only. Bits 2:0 hold the channel count (the value 000 means eight), bits 7:3 hold the interrupt number, bit 8 is 1 when each channel has its own interrupt line, and bit 9 is 0.
- R8: Count and start-value registers are CNT_W bits wide. Writing all ones to them and reading back returns a mask of CNT_W ones, zero-extended.
- R9: With separate lines, an event on channel n pulses only output line n. With the shared arrangement, events on any channel pulse the single output line.
- R10: After reset, every register reads zero except the configuration word, all channels are stopped, and no interrupt line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_o | output | IRQ_LINES | Interrupt pulses: N_TIMERS lines if separate, else 1 |

## Verification
The bench builds two copies of the block. The first uses the defaults: four channels, 16-bit counters and 16-bit prescaler, separate lines and interrupt number 8. This copy exercises per-line routing, the period arithmetic over several prescaler and start-value pairs, one-shot stopping and the control-bit semantics. The second copy has two channels, 8-bit counters and a shared line with interrupt number 3. It brings in the shared routing, a second configuration word and a narrower width mask.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

  // control word bit positions
  localparam int CTL_RUN = 0;
  localparam int CTL_RPT = 1;
  localparam int CTL_LD  = 2;
  localparam int CTL_IE  = 3;
  localparam int CTL_EVT = 4;
  localparam int CTL_W   = 5;

  // global word addresses
  localparam int REG_PRE_CNT = 0;
  localparam int REG_PRE_RLD = 1;
  localparam int REG_CFG     = 2;

  // slot inside a channel's four-word block
  localparam int SLOT_CNT = 0;
  localparam int SLOT_RLD = 1;
  localparam int SLOT_CTL = 2;

  localparam int ADDR_W = 6;
  localparam int BLK_W  = ADDR_W - 2;

  // configuration word layout
  function automatic logic [31:0] cfg_word(input int unsigned n_tim,
                                           input int unsigned irq_num,
                                           input bit sep);
    logic [31:0] w;
    w      = '0;
    w[2:0] = 3'(n_tim);
    w[7:3] = 5'(irq_num);
    w[8]   = sep;
    w[9]   = 1'b0;
    return w;
  endfunction

  // clock cycles between two events of a repeating channel
  function automatic longint unsigned event_period(input longint unsigned pre_rld,
                                                   input longint unsigned tim_rld);
    return (pre_rld + 1) * (tim_rld + 1);
  endfunction

  // channel block number for a word address (0 = global block)
  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction

endpackage

// File: rtl/ttb_prescaler.sv
module ttb_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic [PRE_W-1:0] wdata,
  output logic [PRE_W-1:0] cnt,
  output logic [PRE_W-1:0] rld,
  output logic             tick
);

  logic at_zero;
  assign at_zero = (cnt == '0);
  assign tick    = at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      if (wr_rld) rld <= wdata;
      if (wr_cnt)       cnt <= wdata;
      else if (at_zero) cnt <= rld;
      else              cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
  import ttb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] wdata_cnt,
  input  logic [CTL_W-1:0] wdata_ctl,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld,
  output logic             run,
  output logic             rpt,
  output logic             ie,
  output logic             evt_flag,
  output logic             uf,
  output logic             irq_evt
);

  logic do_load;
  logic at_zero;

  assign at_zero = (cnt == '0);
  assign uf      = tick && run && at_zero;
  assign irq_evt = uf && ie;
  assign do_load = wr_ctl && wdata_ctl[CTL_LD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rld      <= '0;
      run      <= 1'b0;
      rpt      <= 1'b0;
      ie       <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      if (wr_rld) rld <= wdata_cnt;

      // count: direct write, then load action, then ticking
      if (wr_cnt)                cnt <= wdata_cnt;
      else if (do_load)          cnt <= rld;
      else if (tick && run) begin
        if (!at_zero)            cnt <= cnt - 1'b1;
        else if (rpt)            cnt <= rld;
      end

      // mode bits
      if (wr_ctl) begin
        run <= wdata_ctl[CTL_RUN];
        rpt <= wdata_ctl[CTL_RPT];
        ie  <= wdata_ctl[CTL_IE];
      end else if (uf && !rpt) begin
        run <= 1'b0;
      end

      // event flag: a new event wins over a clearing write
      if (irq_evt)                              evt_flag <= 1'b1;
      else if (wr_ctl && wdata_ctl[CTL_EVT])    evt_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/ttb_irq_route.sv
module ttb_irq_route #(
  parameter int N_TIMERS     = 4,
  parameter bit SEPARATE_IRQ = 1'b1,
  localparam int IRQ_LINES   = SEPARATE_IRQ ? N_TIMERS : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_TIMERS-1:0]  evt,
  output logic [IRQ_LINES-1:0] irq
);

  logic [IRQ_LINES-1:0] irq_d;

  generate
    if (SEPARATE_IRQ) begin : g_sep
      assign irq_d = evt;
    end else begin : g_shared
      assign irq_d = |evt;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= '0;
    else        irq <= irq_d;
  end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import ttb_pkg::*;
#(
  parameter int N_TIMERS     = 4,
  parameter int CNT_W        = 16,
  parameter int PRE_W        = 16,
  parameter bit SEPARATE_IRQ = 1'b1,
  parameter int IRQ_NUM      = 8,
  localparam int IRQ_LINES   = SEPARATE_IRQ ? N_TIMERS : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [IRQ_LINES-1:0] irq_o
);

  localparam logic [31:0] CFG = cfg_word(N_TIMERS, IRQ_NUM, SEPARATE_IRQ);

  logic [BLK_W-1:0] blk;
  logic [1:0]       slot;
  assign blk  = blk_of(bus_addr);
  assign slot = bus_addr[1:0];

  // prescaler
  logic             pre_tick;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_rld;
  logic             pre_wr_cnt;
  logic             pre_wr_rld;

  assign pre_wr_cnt = bus_wr && (bus_addr == ADDR_W'(REG_PRE_CNT));
  assign pre_wr_rld = bus_wr && (bus_addr == ADDR_W'(REG_PRE_RLD));

  ttb_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_cnt (pre_wr_cnt),
    .wr_rld (pre_wr_rld),
    .wdata  (bus_wdata[PRE_W-1:0]),
    .cnt    (pre_cnt),
    .rld    (pre_rld),
    .tick   (pre_tick)
  );

  // channels
  logic [CNT_W-1:0]    tim_cnt [N_TIMERS];
  logic [CNT_W-1:0]    tim_rld [N_TIMERS];
  logic [N_TIMERS-1:0] tim_run;
  logic [N_TIMERS-1:0] tim_rpt;
  logic [N_TIMERS-1:0] tim_ie;
  logic [N_TIMERS-1:0] tim_flag;
  logic [N_TIMERS-1:0] tim_uf;
  logic [N_TIMERS-1:0] tim_evt;

  generate
    for (genvar n = 0; n < N_TIMERS; n++) begin : g_ch
      logic hit;
      assign hit = bus_wr && (blk == BLK_W'(n + 1));

      ttb_channel #(.CNT_W(CNT_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (pre_tick),
        .wr_cnt    (hit && (slot == 2'(SLOT_CNT))),
        .wr_rld    (hit && (slot == 2'(SLOT_RLD))),
        .wr_ctl    (hit && (slot == 2'(SLOT_CTL))),
        .wdata_cnt (bus_wdata[CNT_W-1:0]),
        .wdata_ctl (bus_wdata[CTL_W-1:0]),
        .cnt       (tim_cnt[n]),
        .rld       (tim_rld[n]),
        .run       (tim_run[n]),
        .rpt       (tim_rpt[n]),
        .ie        (tim_ie[n]),
        .evt_flag  (tim_flag[n]),
        .uf        (tim_uf[n]),
        .irq_evt   (tim_evt[n])
      );
    end
  endgenerate

  ttb_irq_route #(.N_TIMERS(N_TIMERS), .SEPARATE_IRQ(SEPARATE_IRQ)) u_route (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (tim_evt),
    .irq   (irq_o)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (blk == '0) begin
        case (slot)
          2'(REG_PRE_CNT): bus_rdata = 32'(pre_cnt);
          2'(REG_PRE_RLD): bus_rdata = 32'(pre_rld);
          2'(REG_CFG):     bus_rdata = CFG;
          default:         bus_rdata = '0;
        endcase
      end else begin
        for (int n = 0; n < N_TIMERS; n++) begin
          if (blk == BLK_W'(n + 1)) begin
            case (slot)
              2'(SLOT_CNT): bus_rdata = 32'(tim_cnt[n]);
              2'(SLOT_RLD): bus_rdata = 32'(tim_rld[n]);
              2'(SLOT_CTL): begin
                bus_rdata[CTL_RUN] = tim_run[n];
                bus_rdata[CTL_RPT] = tim_rpt[n];
                bus_rdata[CTL_IE]  = tim_ie[n];
                bus_rdata[CTL_EVT] = tim_flag[n];
              end
              default: bus_rdata = '0;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
  parameter int N_TIMERS  = 4,
  parameter int IRQ_LINES = 4,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [N_TIMERS-1:0]  uf,
  input logic [N_TIMERS-1:0]  flag,
  input logic [N_TIMERS-1:0]  run,
  input logic [N_TIMERS-1:0]  rpt,
  input logic [IRQ_LINES-1:0] irq,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata
);

  // R1: a channel event only happens on a prescaler tick
  assert_event_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|uf) |-> tick);

  // R5: any interrupt line high implies a raised event flag
  assert_irq_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> (|flag));

  // R4: control words never show the load bit
  assert_load_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr[ADDR_W-1:2] != '0) && (bus_addr[1:0] == 2'd2)) |-> !bus_rdata[2]);

  generate
    for (genvar n = 0; n < N_TIMERS; n++) begin : g_chk
      // R3: one-shot event stops the channel when no write interferes
      assert_oneshot_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (uf[n] && !rpt[n] && !bus_wr) |=> !run[n]);

      // R6: the event flag only drops through a bus write
      assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[n] && !bus_wr) |=> flag[n]);
    end
  endgenerate

endmodule

bind tick_timer_bank ttb_checker #(
  .N_TIMERS  (N_TIMERS),
  .IRQ_LINES (IRQ_LINES),
  .ADDR_W    (ttb_pkg::ADDR_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (pre_tick),
  .uf        (tim_uf),
  .flag      (tim_flag),
  .run       (tim_run),
  .rpt       (tim_rpt),
  .irq       (irq_o),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;

  localparam int CLK_P = 10;
  localparam int NA    = 4;

  // prescaler start, channel start, expected cycles between pulses
  localparam int NVEC = 4;
  localparam int VEC [NVEC][3] = '{
    '{1, 3, 8},
    '{0, 5, 6},
    '{3, 2, 12},
    '{2, 4, 15}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [5:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic [NA-1:0] a_irq;
  logic [0:0]    b_irq;

  tick_timer_bank i_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(a_wr), .bus_rd(a_rd), .bus_addr(a_addr),
    .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq_o(a_irq));

  tick_timer_bank #(.N_TIMERS(2), .CNT_W(8), .PRE_W(8), .SEPARATE_IRQ(1'b0), .IRQ_NUM(3))
  i_shared (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq_o(b_irq));

  int checks = 0;
  int errors = 0;
  int pulses_a [NA];
  int pulses_b = 0;
  bit finished = 0;

  initial for (int k = 0; k < NA; k++) pulses_a[k] = 0;

  always @(negedge clk) begin
    for (int k = 0; k < NA; k++) if (a_irq[k]) pulses_a[k]++;
    if (b_irq[0]) pulses_b++;
  end

  function automatic int ta(input int n, input int slot);
    return 4 + 4 * n + slot;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input int a, input logic [31:0] d);
    @(negedge clk);
    if (s == 0) begin a_wr = 1; a_addr = 6'(a); a_wdata = d; end
    else        begin b_wr = 1; b_addr = 6'(a); b_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(input int s, input int a, output logic [31:0] d);
    @(negedge clk);
    if (s == 0) begin a_rd = 1; a_addr = 6'(a); end
    else        begin b_rd = 1; b_addr = 6'(a); end
    #1;
    d = (s == 0) ? a_rdata : b_rdata;
    a_rd = 0; b_rd = 0;
  endtask

  task automatic wait_irq(input int s, input int l, output int c);
    int i;
    i = 0;
    c = -1;
    while (c < 0 && i < 3000) begin
      @(negedge clk);
      i++;
      if ((s == 0 && a_irq[l]) || (s == 1 && b_irq[0])) c = i;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c;
    int snap [NA];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    check("R10 irq lines", a_irq, 0);
    rd(0, 1, d); check("R10 prescaler start", d, 0);
    for (int n = 0; n < NA; n++) begin
      rd(0, ta(n, 2), d); check("R10 control", d, 0);
      rd(0, ta(n, 0), d); check("R10 count", d, 0);
    end
    rd(1, ta(1, 2), d); check("R10 shared control", d, 0);

    // R7: configuration word, and its read-only nature
    rd(0, 2, d); check("R7 cfg separate", d, 32'h144);
    wr(0, 2, 32'hFFFF_FFFF);
    rd(0, 2, d); check("R7 cfg unchanged", d, 32'h144);
    rd(1, 2, d); check("R7 cfg shared", d, 32'h01A);

    // R1 / R2: period table on channel 0 (run|repeat|load|ie, plus flag clear)
    for (int v = 0; v < NVEC; v++) begin
      wr(0, ta(0, 2), 32'h10);
      wr(0, 1, 32'(VEC[v][0]));
      wr(0, 0, 32'h0);
      wr(0, ta(0, 1), 32'(VEC[v][1]));
      wr(0, ta(0, 2), 32'h1F);
      wait_irq(0, 0, c);
      wait_irq(0, 0, c);
      wait_irq(0, 0, c);
      check("R1 R2 event period", c, VEC[v][2]);
    end
    rd(0, ta(0, 2), d); check("R5 flag set after event", d[4], 1);

    // stop channel 0, clear its flag
    wr(0, ta(0, 2), 32'h10);
    wr(0, 1, 32'h0);
    repeat (4) @(negedge clk);

    // R3 / R9: one-shot on channel 1, other lines stay quiet
    for (int k = 0; k < NA; k++) snap[k] = pulses_a[k];
    wr(0, ta(1, 1), 32'd3);
    wr(0, ta(1, 2), 32'h0D);
    wait_irq(0, 1, c);
    check("R3 one-shot fired", c > 0, 1);
    repeat (30) @(negedge clk);
    check("R3 single event", pulses_a[1] - snap[1], 1);
    check("R9 line 0 quiet", pulses_a[0] - snap[0], 0);
    check("R9 line 2 quiet", pulses_a[2] - snap[2], 0);
    rd(0, ta(1, 2), d); check("R3 run cleared, flag kept", d, 32'h18);
    rd(0, ta(1, 0), d); check("R3 count at zero", d, 0);

    // R6: writing 0 keeps flag, writing 1 clears it
    wr(0, ta(1, 2), 32'h08);
    rd(0, ta(1, 2), d); check("R6 write 0 keeps flag", d, 32'h18);
    wr(0, ta(1, 2), 32'h18);
    rd(0, ta(1, 2), d); check("R6 write 1 clears flag", d, 32'h08);

    // R4: load action
    wr(0, ta(1, 2), 32'h04);
    rd(0, ta(1, 0), d); check("R4 load copies start", d, 3);
    rd(0, ta(1, 2), d); check("R4 load reads zero", d, 0);

    // R5: no interrupt enable, no flag, no pulse
    snap[2] = pulses_a[2];
    wr(0, ta(2, 1), 32'd2);
    wr(0, ta(2, 2), 32'h07);
    repeat (40) @(negedge clk);
    check("R5 no pulse without ie", pulses_a[2] - snap[2], 0);
    rd(0, ta(2, 2), d); check("R5 no flag without ie", d, 32'h03);
    wr(0, ta(2, 2), 32'h00);

    // R8: width mask
    wr(0, ta(3, 1), 32'hFFFF_FFFF);
    rd(0, ta(3, 1), d); check("R8 mask 16 bit", d, 32'h0000_FFFF);
    wr(1, ta(0, 1), 32'hFFFF_FFFF);
    rd(1, ta(0, 1), d); check("R8 mask 8 bit", d, 32'h0000_00FF);

    // R9: shared line carries channel 1 of second copy
    wr(1, 1, 32'h0);
    wr(1, ta(1, 1), 32'd4);
    wr(1, ta(1, 2), 32'h0F);
    wait_irq(1, 0, c);
    wait_irq(1, 0, c);
    wait_irq(1, 0, c);
    check("R9 R2 shared line period", c, 5);
    rd(1, ta(1, 2), d); check("R9 shared flag", d[4], 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule